// File: doc/BRIEF.md
# Block Floating-Point Barrel Shifter

This unit is the shift stage of a 16-bit fixed-point datapath. A 16-bit operand is first placed in the upper or lower half of a 32-bit field. It is then moved left or right by a signed amount, and the outcome is stored in a 32-bit result register. Beside plain logical and arithmetic shifts, the unit can report how many redundant sign bits an operand carries, as a non-positive exponent. It can also normalize a mantissa by such an exponent and denormalize (align) a mantissa to a common exponent. Together these let software carry values in a block floating-point or multiword floating-point form.

Multiprecision values are built in two steps. The first shift writes the result register. A second shift, issued with the merge control set, ORs its 32-bit outcome into the stored value, for example to join an upper and a lower word. The result register is visible on the port in the cycle after the strobe, so the next arithmetic stage can consume it directly.

Top module: `bfp_shifter`

## Requirements
- R1: While `rst` is high at a clock edge, `result` becomes 0 and `exp_out` becomes 0.
- R2: With `en` low, `result` and `exp_out` keep their values across the clock edge. Operation codes 5 to 7 also leave both unchanged.
- R3: Operation code 0 (logical shift) uses the signed value of `amt` as the count: a positive count shifts left and a negative count shifts right. Vacated bits are zero-filled on both sides.
- R4: Operation code 1 (arithmetic shift) uses `amt` like R3, but a right shift fills vacated bits with bit 31 of the placed field.
- R5: A count of magnitude 32 or more gives all zeros. The exception is an arithmetic right shift (codes 1 and 3), which gives 32 copies of bit 31 of the placed field.
- R6: With `hi_sel`=1 the operand occupies bits 31:16 and bits 15:0 are zero. With `hi_sel`=0 it occupies bits 15:0, and bits 31:16 are copies of operand bit 15 for codes 1 and 3 and zero for codes 0 and 2.
- R7: Operation code 2 (normalize) treats `amt` as an exponent and shifts the placed field left by −`amt`, zero-filled. A positive `amt` therefore shifts right.
- R8: Operation code 3 (denormalize) shifts the placed field right by `amt`, filling with the sign. A negative `amt` shifts left.
- R9: Operation code 4 (derive exponent) loads `exp_out` with minus the number of operand bits below bit 15 that equal bit 15 before the first differing bit, giving a range of −15 to 0. An all-zero or all-one operand gives −15. `result` is unchanged.
- R10: For codes 0 to 3, `or_mode`=1 stores the bitwise OR of the new shifted value and the previous `result`. `or_mode`=0 replaces `result`.
- R11: Each stored value appears on the outputs one clock after the strobe. `exp_out` changes only on code 4 (or reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Operation strobe; the registers update only when high |
| op | input | 3 | Operation code: 0 logical, 1 arithmetic, 2 normalize, 3 denormalize, 4 derive exponent |
| hi_sel | input | 1 | Placement of the operand in the upper (1) or lower (0) half of the 32-bit field |
| or_mode | input | 1 | Merge the new shift outcome into the stored result |
| amt | input | 8 | Signed shift count or exponent, two's complement |
| din | input | 16 | Operand |
| result | output | 32 | Registered shift result |
| exp_out | output | 8 | Registered derived exponent, two's complement |

## Verification
Two functions that can meet in one cycle are the merge into the stored result and an out-of-range count that saturates the shift. When both fall on the same strobe, the saturated word, whether zeros or sign copies, must be ORed in rather than replacing the stored value. The bench provokes this case with directed strobes that pair a counts of ±40 with `or_mode` set on top of a non-zero stored word. The random stream also produces it often, because a large share of counts fall outside ±31 and `or_mode` is randomized. A second overlap is an exponent strobe issued with `or_mode` high, which must leave `result` alone. Every outcome is judged against a bench model that places, shifts and merges with native 32-bit operators.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef enum logic [2:0] {
    OP_LSH    = 3'd0,
    OP_ASH    = 3'd1,
    OP_NORM   = 3'd2,
    OP_DENORM = 3'd3,
    OP_EXPD   = 3'd4
  } bfp_op_e;

  typedef struct packed {
    logic is_shift;   // writes the result register
    logic arith;      // sign fill on right shifts
    logic negate;     // count is the negated amount
  } bfp_ctl_t;
endpackage

// File: rtl/bfp_place.sv
module bfp_place #(
  parameter int DATA_W = 16,
  localparam int FW = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] din,
  input  logic              hi_sel,
  input  logic              sext,
  output logic [FW-1:0]     field
);
  logic ext_bit;
  assign ext_bit = sext & din[DATA_W-1];

  always_comb begin
    if (hi_sel) field = {din, {DATA_W{1'b0}}};
    else        field = {{DATA_W{ext_bit}}, din};
  end
endmodule

// File: rtl/bfp_barrel.sv
module bfp_barrel #(
  parameter int W  = 32,
  parameter int CW = 9,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  field,
  input  logic [CW-1:0] cnt,     // two's complement, positive = left
  input  logic          arith,
  output logic [W-1:0]  shifted
);
  localparam logic [CW-1:0] W_C = CW'(W);

  logic          go_right;
  logic [CW-1:0] mag;
  logic          over;
  logic          fill;

  assign go_right = cnt[CW-1];
  assign mag      = go_right ? (~cnt + 1'b1) : cnt;
  assign over     = (mag >= W_C);
  assign fill     = arith & field[W-1];

  logic [W-1:0] lst [0:SW];
  logic [W-1:0] rst_ [0:SW];

  assign lst[0]  = field;
  assign rst_[0] = field;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [W-1:0] top_fill;
    assign top_fill = fill ? ~({W{1'b1}} >> STEP) : {W{1'b0}};
    assign lst[k+1]  = mag[k] ? (lst[k] << STEP) : lst[k];
    assign rst_[k+1] = mag[k] ? ((rst_[k] >> STEP) | top_fill) : rst_[k];
  end

  always_comb begin
    if (over)          shifted = go_right ? {W{fill}} : {W{1'b0}};
    else if (go_right) shifted = rst_[SW];
    else               shifted = lst[SW];
  end
endmodule

// File: rtl/bfp_expdet.sv
module bfp_expdet #(
  parameter int DATA_W = 16,
  parameter int EXP_W  = 8
) (
  input  logic [DATA_W-1:0] din,
  output logic [EXP_W-1:0]  exp_val
);
  logic [EXP_W-1:0] run_len;
  logic             in_run;

  always_comb begin
    run_len = '0;
    in_run  = 1'b1;
    for (int i = DATA_W - 2; i >= 0; i--) begin
      if (in_run && (din[i] == din[DATA_W-1])) run_len = run_len + 1'b1;
      else                                     in_run  = 1'b0;
    end
    exp_val = ~run_len + 1'b1;
  end
endmodule

// File: rtl/bfp_shifter.sv
module bfp_shifter #(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 8,
  parameter int EXP_W  = 8,
  localparam int RES_W = 2 * DATA_W,
  localparam int CW    = AMT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [2:0]        op,
  input  logic              hi_sel,
  input  logic              or_mode,
  input  logic [AMT_W-1:0]  amt,
  input  logic [DATA_W-1:0] din,
  output logic [RES_W-1:0]  result,
  output logic [EXP_W-1:0]  exp_out
);
  import bfp_pkg::*;

  bfp_op_e  opc;
  bfp_ctl_t ctl;

  assign opc = bfp_op_e'(op);

  always_comb begin
    ctl = '0;
    unique case (opc)
      OP_LSH:    ctl = '{is_shift: 1'b1, arith: 1'b0, negate: 1'b0};
      OP_ASH:    ctl = '{is_shift: 1'b1, arith: 1'b1, negate: 1'b0};
      OP_NORM:   ctl = '{is_shift: 1'b1, arith: 1'b0, negate: 1'b1};
      OP_DENORM: ctl = '{is_shift: 1'b1, arith: 1'b1, negate: 1'b1};
      default:   ctl = '0;
    endcase
  end

  logic [CW-1:0] amt_x;
  logic [CW-1:0] cnt;
  assign amt_x = {amt[AMT_W-1], amt};
  assign cnt   = ctl.negate ? (~amt_x + 1'b1) : amt_x;

  logic [RES_W-1:0] field;
  logic [RES_W-1:0] shifted;
  logic [EXP_W-1:0] exp_val;

  bfp_place #(.DATA_W(DATA_W)) u_place (
    .din    (din),
    .hi_sel (hi_sel),
    .sext   (ctl.arith),
    .field  (field)
  );

  bfp_barrel #(.W(RES_W), .CW(CW)) u_barrel (
    .field   (field),
    .cnt     (cnt),
    .arith   (ctl.arith),
    .shifted (shifted)
  );

  bfp_expdet #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_expdet (
    .din     (din),
    .exp_val (exp_val)
  );

  logic [RES_W-1:0] result_q;
  logic [EXP_W-1:0] exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      exp_q    <= '0;
    end else if (en) begin
      if (ctl.is_shift)
        result_q <= or_mode ? (result_q | shifted) : shifted;
      if (opc == OP_EXPD)
        exp_q <= exp_val;
    end
  end

  assign result  = result_q;
  assign exp_out = exp_q;
endmodule

// File: rtl/bfp_shifter_chk.sv
module bfp_shifter_chk #(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 8,
  parameter int EXP_W  = 8,
  localparam int RES_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [2:0]        op,
  input logic              or_mode,
  input logic [AMT_W-1:0]  amt,
  input logic [RES_W-1:0]  result,
  input logic [EXP_W-1:0]  exp_out
);
  localparam int MIN_EXP = -(DATA_W - 1);

  logic is_shift_op;
  assign is_shift_op = (op <= 3'd3);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(result) && $stable(exp_out)));

  p_sat_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd0 && !or_mode && $signed(amt) <= -32) |=> (result == '0));

  p_exp_range_r9: assert property (@(posedge clk) disable iff (rst)
    ($signed(exp_out) >= MIN_EXP) && ($signed(exp_out) <= 0));

  p_expd_keeps_result_r9: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd4) |=> $stable(result));

  p_merge_keeps_bits_r10: assert property (@(posedge clk) disable iff (rst)
    (en && or_mode && is_shift_op) |=> ((result & $past(result)) == $past(result)));

  p_exp_only_on_expd_r11: assert property (@(posedge clk) disable iff (rst)
    (en && op != 3'd4) |=> $stable(exp_out));
endmodule

bind bfp_shifter bfp_shifter_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W), .EXP_W(EXP_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .op      (op),
  .or_mode (or_mode),
  .amt     (amt),
  .result  (result),
  .exp_out (exp_out)
);

// File: tb/tb_bfp_shifter.sv
module tb_bfp_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        hi_sel = 1'b0;
  logic        or_mode = 1'b0;
  logic [7:0]  amt = 8'd0;
  logic [15:0] din = 16'd0;
  logic [31:0] result;
  logic [7:0]  exp_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] res_m = 32'd0;
  logic [7:0]  exp_m = 8'd0;

  always #5 clk = ~clk;

  bfp_shifter dut (
    .clk(clk), .rst(rst), .en(en), .op(op), .hi_sel(hi_sel),
    .or_mode(or_mode), .amt(amt), .din(din), .result(result), .exp_out(exp_out)
  );

  function automatic logic [31:0] mdl_shift(logic [15:0] d, bit hi, int opc, int a);
    bit ar;
    int c;
    logic signed [31:0] f;
    ar = (opc == 1) || (opc == 3);
    c  = (opc >= 2) ? -a : a;
    if (hi)      f = {d, 16'h0000};
    else if (ar) f = {{16{d[15]}}, d};
    else         f = {16'h0000, d};
    if (c >= 32)  return 32'd0;
    if (c <= -32) return ar ? {32{f[31]}} : 32'd0;
    if (c >= 0)   return f << c;
    if (ar)       return f >>> (-c);
    return f >> (-c);
  endfunction

  function automatic logic [7:0] mdl_exp(logic [15:0] d);
    int n = 0;
    for (int i = 14; i >= 0; i--) begin
      if (d[i] != d[15]) break;
      n++;
    end
    return 8'(-n);
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s result act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s exp_out act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  // Apply one strobe, update the model, compare one clock later.
  task automatic step(bit e, int o, bit h, bit om, int a, logic [15:0] d, string tag);
    en = e; op = 3'(o); hi_sel = h; or_mode = om; amt = 8'(a); din = d;
    if (e && o <= 3) begin
      logic [31:0] s = mdl_shift(d, h, o, a);
      res_m = om ? (res_m | s) : s;
    end
    if (e && o == 4) exp_m = mdl_exp(d);
    @(posedge clk);
    #1;
    check32(tag, result, res_m);
    check8({tag, "/R11"}, exp_out, exp_m);
  endtask

  function automatic string tag_of(bit e, int o, bit om, int a);
    int c = (o >= 2) ? -a : a;
    if (!e || o > 4)           return "R2";
    if (o == 4)                return "R9";
    if (c >= 32 || c <= -32)   return "R5";
    if (om)                    return "R10";
    case (o)
      0: return "R3";
      1: return "R4";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED_0B1F));
    repeat (3) @(posedge clk);
    #1;
    check32("R1", result, 32'd0);
    check8("R1", exp_out, 8'd0);
    rst = 1'b0;

    // Directed corner cases
    step(1, 0, 0, 0,   4, 16'h8001, "R3");
    step(1, 0, 1, 0,  -4, 16'h8001, "R3");
    step(1, 1, 1, 0,  -8, 16'h8001, "R4");
    step(1, 1, 0, 0,  -1, 16'h8000, "R6");
    step(1, 0, 0, 0,   0, 16'h8000, "R6");
    step(1, 2, 0, 0,   0, 16'hF000, "R6");
    step(1, 0, 1, 0,   0, 16'h1234, "R6");
    step(1, 0, 0, 0,  32, 16'hFFFF, "R5");
    step(1, 1, 1, 0, -40, 16'h8000, "R5");
    step(1, 0, 1, 0, -32, 16'h8000, "R5");
    step(1, 0, 1, 0,  31, 16'h0001, "R3");
    step(1, 4, 0, 0,   0, 16'h0000, "R9");
    step(1, 4, 0, 0,   0, 16'hFFFF, "R9");
    step(1, 4, 0, 0,   0, 16'h4000, "R9");
    step(1, 4, 0, 1,   0, 16'h0001, "R9");
    step(1, 4, 0, 0,   0, 16'hC000, "R9");
    step(1, 2, 1, 0,  -1, 16'h2000, "R7");
    step(1, 2, 1, 0,   3, 16'h2000, "R7");
    step(1, 3, 1, 0,   5, 16'hA000, "R8");
    step(1, 3, 0, 0,  -2, 16'h0003, "R8");
    step(1, 0, 1, 0,   0, 16'hABCD, "R10");
    step(1, 0, 0, 1,   0, 16'h1234, "R10");
    step(1, 1, 0, 1,  40, 16'h7FFF, "R5");
    step(1, 1, 1, 1, -40, 16'h8000, "R5");
    step(0, 0, 0, 0,   1, 16'hFFFF, "R2");
    step(1, 5, 0, 0,   1, 16'hFFFF, "R2");
    step(1, 7, 1, 1,   1, 16'h0001, "R2");

    // Constrained random stream
    for (int n = 0; n < 4000; n++) begin
      bit e  = ($urandom_range(0, 9) != 0);
      int o  = ($urandom_range(0, 9) == 0) ? int'($urandom_range(5, 7)) : int'($urandom_range(0, 4));
      bit h  = 1'($urandom);
      bit om = ($urandom_range(0, 3) == 0);
      int a  = ($urandom_range(0, 3) == 0) ? int'($signed(8'($urandom)))
                                          : int'($urandom_range(0, 80)) - 40;
      logic [15:0] d;
      case ($urandom_range(0, 3))
        0:       d = 16'($urandom) >> $urandom_range(0, 15);
        1:       d = ~(16'($urandom) >> $urandom_range(0, 15));
        default: d = 16'($urandom);
      endcase
      step(e, o, h, om, a, d, tag_of(e, o, om, a));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule